// File: doc/BRIEF.md
# Microcoded Stack-Machine Sequencer

This block is the control core of a small stack-oriented processor. A microcode table inside it steps through three kinds of microstep: an instruction fetch, a decode, and one or more execute steps. Each microword drives the select of the address bus, the source of the internal data bus, the evaluation-stack operation, the instruction-pointer and operand-register updates, and names the microcode address that comes next. Instructions are single bytes. The upper nibble is the opcode and the lower nibble is an immediate that is merged into the operand register. Operands live on a three-entry register stack, so arithmetic instructions name no registers.

Memory is a read port that returns a byte in the same cycle the address is presented. Microcode address 0 is always the fetch and address 1 is always the decode. Decode dispatches to address 16 plus the opcode. The jump instruction takes a second execute step at address 2. Opcodes: 0 prefix, 1 load constant, 2 add, 3 subtract, 4 duplicate, 5 swap, 6 relative jump, 7 to 15 unassigned.

Top module: `useq_core`

## Requirements
- R1: While reset is low, the instruction pointer, operand register, microcode address and all three stack entries read zero. The first microstep after reset is the fetch at address 0.
- R2: In the fetch step (microcode address 0), the instruction register captures the byte read at the instruction pointer, the pointer advances by one (modulo 2^AW), and the next microcode address is 1.
- R3: In the decode step (address 1), the next microcode address is 16 plus the opcode, where the opcode is bits 7:4 of the captured instruction byte.
- R4: Every execute step except the first step of the jump (opcode 6) returns to microcode address 0 on the next cycle.
- R5: The jump takes two execute steps, at 22 and then at 2. In the first step, the operand register becomes its old value ORed with the low nibble. In the second step, the instruction pointer becomes its current value plus the low AW bits of the operand register (modulo 2^AW), and the operand register clears.
- R6: The prefix (opcode 0) sets the operand register to ((operand OR low nibble) shifted left by 4) modulo 2^W. The stack and the pointer are left unchanged.
- R7: Load constant (opcode 1) pushes (operand OR low nibble): C takes B, B takes A, and A takes the value. The old C is lost without any indication.
- R8: Add (opcode 2) sets A to A+B and subtract (opcode 3) sets A to B-A, both modulo 2^W. In both cases B takes C and C keeps its value.
- R9: Duplicate (opcode 4) pushes a copy of A. Swap (opcode 5) exchanges A and B and leaves C unchanged.
- R10: Unassigned opcodes 7 to 15 leave the stack and the pointer unchanged. They clear the operand register, and the sequencer goes back to the fetch.
- R11: Every opcode other than the prefix and the first jump step clears the operand register when it completes.
- R12: The memory read strobe is high only in the fetch step. The address bus carries the instruction pointer during the fetch and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | AW | Address bus to the program memory |
| mem_rd | output | 1 | Read strobe, high in the fetch step |
| mem_rdata | input | 8 | Byte returned for mem_addr in the same cycle |
| ip_o | output | AW | Instruction pointer |
| opnd_o | output | W | Operand register |
| upc_o | output | 5 | Current microcode address |
| stk_a | output | W | Stack top (A) |
| stk_b | output | W | Stack middle (B) |
| stk_c | output | W | Stack bottom (C) |

## Verification
A fixed arithmetic program pushes past the stack depth and then adds, subtracts, duplicates and swaps. Its results separate a correct push order and drop of the bottom entry from a mis-wired shift, and a B-A subtraction from an A-B one. A second program chains prefixes into a three-nibble constant, runs unassigned opcodes after a pending prefix, and jumps forward over bytes that must not execute. This exposes an operand register that is not merged, not shifted or not cleared. A pseudo-random byte stream then mixes every opcode and backward jumps, and wraps the pointer, so that the dispatch address, the two-step jump and the wrap arithmetic are compared with the model on every cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UA_W = 5;
  localparam int IB_W = 8;

  localparam logic [UA_W-1:0] UA_FETCH  = 5'd0;
  localparam logic [UA_W-1:0] UA_DECODE = 5'd1;
  localparam logic [UA_W-1:0] UA_JMP2   = 5'd2;

  localparam logic [3:0] OPC_PFX = 4'd0;
  localparam logic [3:0] OPC_LDC = 4'd1;
  localparam logic [3:0] OPC_ADD = 4'd2;
  localparam logic [3:0] OPC_SUB = 4'd3;
  localparam logic [3:0] OPC_DUP = 4'd4;
  localparam logic [3:0] OPC_SWP = 4'd5;
  localparam logic [3:0] OPC_JMP = 4'd6;

  typedef enum logic [0:0] {AB_IDLE, AB_IP} abus_e;
  typedef enum logic [2:0] {DB_NONE, DB_MEM, DB_OPND, DB_SUM, DB_DIFF, DB_TOP} dbus_e;
  typedef enum logic [1:0] {SK_HOLD, SK_PUSH, SK_FOLD, SK_SWAP} stk_e;
  typedef enum logic [1:0] {OP_HOLD, OP_CLEAR, OP_SHIFT, OP_MERGE} opr_e;
  typedef enum logic [1:0] {IP_HOLD, IP_INC, IP_JUMP} ipc_e;
  typedef enum logic [0:0] {NX_FIXED, NX_DISPATCH} nxt_e;

  typedef struct packed {
    abus_e           abus;
    dbus_e           dbus;
    stk_e            stk;
    logic            ir_ld;
    ipc_e            ipc;
    opr_e            opr;
    nxt_e            nxt;
    logic [UA_W-1:0] naddr;
  } uword_t;

  function automatic logic [UA_W-1:0] dispatch_addr(input logic [3:0] opc);
    return {1'b1, opc};
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic [UA_W-1:0] upc,
  output uword_t          uw
);

  always_comb begin
    uw = '{abus: AB_IDLE, dbus: DB_NONE, stk: SK_HOLD, ir_ld: 1'b0,
           ipc: IP_HOLD, opr: OP_CLEAR, nxt: NX_FIXED, naddr: UA_FETCH};
    case (upc)
      UA_FETCH: begin
        uw.abus  = AB_IP;
        uw.dbus  = DB_MEM;
        uw.ir_ld = 1'b1;
        uw.ipc   = IP_INC;
        uw.opr   = OP_HOLD;
        uw.naddr = UA_DECODE;
      end
      UA_DECODE: begin
        uw.opr = OP_HOLD;
        uw.nxt = NX_DISPATCH;
      end
      UA_JMP2: begin
        uw.ipc = IP_JUMP;
      end
      dispatch_addr(OPC_PFX): uw.opr = OP_SHIFT;
      dispatch_addr(OPC_LDC): begin
        uw.dbus = DB_OPND;
        uw.stk  = SK_PUSH;
      end
      dispatch_addr(OPC_ADD): begin
        uw.dbus = DB_SUM;
        uw.stk  = SK_FOLD;
      end
      dispatch_addr(OPC_SUB): begin
        uw.dbus = DB_DIFF;
        uw.stk  = SK_FOLD;
      end
      dispatch_addr(OPC_DUP): begin
        uw.dbus = DB_TOP;
        uw.stk  = SK_PUSH;
      end
      dispatch_addr(OPC_SWP): uw.stk = SK_SWAP;
      dispatch_addr(OPC_JMP): begin
        uw.opr   = OP_MERGE;
        uw.naddr = UA_JMP2;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import useq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  uword_t          uw,
  input  logic [3:0]      opcode,
  output logic [UA_W-1:0] upc
);

  logic [UA_W-1:0] upc_nxt;

  always_comb begin
    if (uw.nxt == NX_DISPATCH) upc_nxt = dispatch_addr(opcode);
    else                       upc_nxt = uw.naddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= UA_FETCH;
    else        upc <= upc_nxt;
  end

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UA_FETCH) |=> (upc == UA_DECODE));

  assert_decode_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UA_DECODE) |=> (upc == {1'b1, $past(opcode)}));

  assert_exec_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upc[UA_W-1] && (upc[3:0] != OPC_JMP)) |=> (upc == UA_FETCH));

  assert_jump_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == dispatch_addr(OPC_JMP)) |=> (upc == UA_JMP2));

endmodule

// File: rtl/useq_stack.sv
module useq_stack
  import useq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  stk_e         op,
  input  logic [W-1:0] din,
  output logic [W-1:0] a,
  output logic [W-1:0] b,
  output logic [W-1:0] c,
  output logic         push_ev,
  output logic         fold_ev
);

  assign push_ev = (op == SK_PUSH);
  assign fold_ev = (op == SK_FOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a <= '0;
      b <= '0;
      c <= '0;
    end else begin
      case (op)
        SK_PUSH: begin
          a <= din;
          b <= a;
          c <= b;
        end
        SK_FOLD: begin
          a <= din;
          b <= c;
        end
        SK_SWAP: begin
          a <= b;
          b <= a;
        end
        default: ;
      endcase
    end
  end

  assert_push_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> (b == $past(a)) && (c == $past(b)));

  assert_fold_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fold_ev |=> (b == $past(c)) && (c == $past(c)));

  assert_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SK_SWAP) |=> (a == $past(b)) && (b == $past(a)) && $stable(c));

endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  input  logic [IB_W-1:0] mem_rdata,
  output logic [AW-1:0]   ip_o,
  output logic [W-1:0]    opnd_o,
  output logic [UA_W-1:0] upc_o,
  output logic [W-1:0]    stk_a,
  output logic [W-1:0]    stk_b,
  output logic [W-1:0]    stk_c
);

  localparam int NIB = 4;

  function automatic logic [W-1:0] opnd_merge(input logic [W-1:0] o, input logic [NIB-1:0] n);
    return o | W'(n);
  endfunction

  function automatic logic [W-1:0] opnd_shift(input logic [W-1:0] o, input logic [NIB-1:0] n);
    return opnd_merge(o, n) << NIB;
  endfunction

  function automatic logic [AW-1:0] jump_target(input logic [AW-1:0] p, input logic [W-1:0] o);
    return p + o[AW-1:0];
  endfunction

  logic [UA_W-1:0] upc;
  uword_t          uw;
  logic [IB_W-1:0] ireg;
  logic [W-1:0]    oreg;
  logic [AW-1:0]   ip;
  logic [W-1:0]    dbus;
  logic            push_ev, fold_ev;
  logic            fetch_ev;

  useq_rom u_rom (.upc(upc), .uw(uw));

  useq_nextaddr u_nxt (
    .clk(clk), .rst_n(rst_n), .uw(uw),
    .opcode(ireg[IB_W-1 -: 4]), .upc(upc)
  );

  always_comb begin
    case (uw.dbus)
      DB_MEM:  dbus = W'(mem_rdata);
      DB_OPND: dbus = opnd_merge(oreg, ireg[NIB-1:0]);
      DB_SUM:  dbus = stk_a + stk_b;
      DB_DIFF: dbus = stk_b - stk_a;
      DB_TOP:  dbus = stk_a;
      default: dbus = '0;
    endcase
  end

  useq_stack #(.W(W)) u_stk (
    .clk(clk), .rst_n(rst_n), .op(uw.stk), .din(dbus),
    .a(stk_a), .b(stk_b), .c(stk_c), .push_ev(push_ev), .fold_ev(fold_ev)
  );

  assign fetch_ev = (uw.abus == AB_IP);
  assign mem_rd   = fetch_ev;
  assign mem_addr = fetch_ev ? ip : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ireg <= '0;
      oreg <= '0;
      ip   <= '0;
    end else begin
      if (uw.ir_ld) ireg <= dbus[IB_W-1:0];
      case (uw.opr)
        OP_CLEAR: oreg <= '0;
        OP_SHIFT: oreg <= opnd_shift(oreg, ireg[NIB-1:0]);
        OP_MERGE: oreg <= opnd_merge(oreg, ireg[NIB-1:0]);
        default:  ;
      endcase
      case (uw.ipc)
        IP_INC:  ip <= ip + 1'b1;
        IP_JUMP: ip <= jump_target(ip, oreg);
        default: ;
      endcase
    end
  end

  assign ip_o   = ip;
  assign opnd_o = oreg;
  assign upc_o  = upc;

  assert_fetch_ip_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (ip == $past(ip) + 1'b1));

  assert_rd_only_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (upc == UA_FETCH));

  assert_opnd_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upc[UA_W-1] && (upc[3:0] != OPC_PFX) && (upc[3:0] != OPC_JMP)) |=> (oreg == '0));

  assert_stack_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upc[UA_W-1] && (upc[3:0] > OPC_JMP)) |=> $stable(stk_a) && $stable(stk_b) && $stable(stk_c));

endmodule

// File: tb/tb_useq_core.sv
module tb_useq_core;

  localparam int W  = 16;
  localparam int AW = 8;
  localparam int MW = (1 << W) - 1;
  localparam int MA = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [7:0]    mem_rdata;
  logic [AW-1:0] ip_o;
  logic [W-1:0]  opnd_o;
  logic [4:0]    upc_o;
  logic [W-1:0]  stk_a, stk_b, stk_c;

  logic [7:0] prog [256];

  int vectors = 0;
  int errors  = 0;

  int m_ip, m_a, m_b, m_c, m_or, m_ir, m_ph;

  always #4 clk = ~clk;

  assign mem_rdata = prog[mem_addr];

  useq_core #(.W(W), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .ip_o(ip_o), .opnd_o(opnd_o), .upc_o(upc_o),
    .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int eu;
    case (m_ph)
      0: eu = 0;
      1: eu = 1;
      2: eu = 16 + (m_ir >> 4);
      default: eu = 2;
    endcase
    chk("R2/R3/R4 upc", int'(upc_o), eu);
    chk("R2/R5 ip", int'(ip_o), m_ip);
    chk("R6/R10/R11 operand", int'(opnd_o), m_or);
    chk("R7/R8/R9 A", int'(stk_a), m_a);
    chk("R7/R8/R9 B", int'(stk_b), m_b);
    chk("R7/R8/R9 C", int'(stk_c), m_c);
    chk("R12 mem_rd", int'(mem_rd), (m_ph == 0) ? 1 : 0);
    chk("R12 mem_addr", int'(mem_addr), (m_ph == 0) ? m_ip : 0);
  endtask

  task automatic model_step();
    int op, val, t;
    case (m_ph)
      0: begin
        m_ir = int'(prog[m_ip]);
        m_ip = (m_ip + 1) & MA;
        m_ph = 1;
      end
      1: m_ph = 2;
      2: begin
        op  = m_ir >> 4;
        val = (m_or | (m_ir & 15)) & MW;
        m_ph = 0;
        m_or = 0;
        case (op)
          0: m_or = (val << 4) & MW;
          1: begin m_c = m_b; m_b = m_a; m_a = val; end
          2: begin m_a = (m_a + m_b) & MW; m_b = m_c; end
          3: begin m_a = (m_b - m_a) & MW; m_b = m_c; end
          4: begin m_c = m_b; m_b = m_a; end
          5: begin t = m_a; m_a = m_b; m_b = t; end
          6: begin m_or = val; m_ph = 3; end
          default: ;
        endcase
      end
      default: begin
        m_ip = (m_ip + m_or) & MA;
        m_or = 0;
        m_ph = 0;
      end
    endcase
  endtask

  task automatic run_prog(input int cycles);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ip", int'(ip_o), 0);
    chk("R1 upc", int'(upc_o), 0);
    chk("R1 operand", int'(opnd_o), 0);
    chk("R1 stack", int'(stk_a | stk_b | stk_c), 0);
    m_ip = 0; m_a = 0; m_b = 0; m_c = 0; m_or = 0; m_ir = 0; m_ph = 0;
    rst_n = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      compare_all();
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 8'h70;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    // Program 1: stack arithmetic, overflow drop (R7), add/sub (R8), dup/swap (R9)
    clear_prog();
    prog[0] = 8'h13; prog[1] = 8'h15; prog[2] = 8'h20; prog[3] = 8'h40;
    prog[4] = 8'h17; prog[5] = 8'h11; prog[6] = 8'h30; prog[7] = 8'h50;
    prog[8] = 8'h30; prog[9] = 8'h60; prog[10] = 8'h0F; prog[11] = 8'h6D;
    run_prog(80);
    // expected final stack after SUB,REV,SUB: A=FFFE, B=8, C=8
    chk("R8 final A", int'(stk_a), 16'hFFFE);
    chk("R7 final C", int'(stk_c), 8);

    // Program 2: prefix chain (R6), unassigned opcodes clear operand (R10),
    // forward jump skips bytes (R5)
    clear_prog();
    prog[0] = 8'h01; prog[1] = 8'h02; prog[2] = 8'h13; prog[3] = 8'h05;
    prog[4] = 8'h8A; prog[5] = 8'h10; prog[6] = 8'h9F; prog[7] = 8'h62;
    prog[8] = 8'h1F; prog[9] = 8'h1F; prog[10] = 8'h21; prog[11] = 8'h0F;
    prog[12] = 8'h6D;
    run_prog(80);
    chk("R6 constant 0x123", int'(stk_a), 16'h0123);
    chk("R5 skipped bytes", int'(stk_b), 0);

    // Program 3: pseudo-random byte stream covering every opcode and ip wrap
    clear_prog();
    seed = 32'h1234_5678;
    for (int i = 0; i < 256; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      prog[i] = seed[23:16];
    end
    run_prog(3000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule